// File: doc/BRIEF.md
# Calibrated Timekeeping Divider

This block turns a nominal 32,768 Hz oscillator clock into a once-per-second tick and a once-per-minute tick. Its rate can be trimmed digitally: instead of changing the division ratio, the divider holds its count for a short while (slowing the clock) or jumps its count forward (speeding it up), once in selected minutes of a repeating 64-minute cycle. A 6-bit calibration input selects how many minutes of the cycle are trimmed and in which direction.

It also drives a frequency-test output, taken from a free-running prescaler that never sees the trim. With default parameters this output is a 512 Hz square wave, so the oscillator error can be measured directly. The output only runs while a set of control conditions holds. A stop input freezes the whole chain.

Top module: `tkdiv_top`

## Requirements
- R1: While `rst_i` is high, `sec_tick_o`, `min_tick_o` and `ft_o` are low, even if the test enable is set. After release, every counter starts from zero.
- R2: An untrimmed second lasts 2^(LOW_BITS+HIGH_BITS) running clock cycles. `sec_tick_o` pulses for one cycle at the end of each second. `min_tick_o` pulses together with every SEC_PER_MIN-th `sec_tick_o` and at no other time.
- R3: `cal_i[4:0]` is a magnitude N and `cal_i[5]` is the direction: 1 speeds up, 0 slows down. A minute whose index m within the cycle satisfies m < 2N has exactly one trimmed second, and that is its first second. N = 0 trims nothing in either direction.
- R4: A slowing trim holds the divider for 2^(LOW_BITS-1) cycles at the start of the second, so that second lasts 2^(LOW_BITS+HIGH_BITS) + 2^(LOW_BITS-1) cycles.
- R5: A speeding trim advances the divider by 2^LOW_BITS extra counts in the first cycle of the second, so that second lasts 2^(LOW_BITS+HIGH_BITS) - 2^LOW_BITS cycles.
- R6: `cal_i` is sampled only at minute boundaries, and the sample governs the minute that starts there. Changing it during a minute does not alter that minute. The first minute after reset is never trimmed.
- R7: The minute index runs 0 to 2^MIN_BITS-1 and then wraps to 0. The last two minutes of the cycle are never trimmed, whatever the magnitude.
- R8: While `stop_i` is high, the divider, the trim state and the test prescaler hold their values. No tick is produced and `ft_o` is low. Counting resumes from the held state when `stop_i` falls.
- R9: When enabled, `ft_o` toggles every 2^(FT_BITS-1) cycles, which is 512 Hz with defaults. The spacing is the same in trimmed and untrimmed seconds.
- R10: `ft_o` is enabled only when all of these hold: `stop_i` = 0, `ftest_i` = 1, `afe_i` = 0, and either `wds_i` = 1 or `wd_zero_i` = 1. Otherwise it is low within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset (power-up) |
| cal_i | input | MAG_BITS+1 | Trim magnitude [MAG_BITS-1:0], direction [MAG_BITS] (1 = faster) |
| stop_i | input | 1 | Freeze the divider and test prescaler |
| ftest_i | input | 1 | Frequency-test request |
| afe_i | input | 1 | Alarm-flag enable; blocks the test output when 1 |
| wds_i | input | 1 | Watchdog steering; test output permitted when 1 |
| wd_zero_i | input | 1 | Watchdog setting is zero; test output permitted when 1 |
| sec_tick_o | output | 1 | One-cycle pulse at the end of each second |
| min_tick_o | output | 1 | One-cycle pulse at the end of each minute |
| ft_o | output | 1 | Frequency-test square wave |

## Verification
A wrong trim decision never shows up as a wrong level on a pin. It shows up as a second that is 2^(LOW_BITS-1) cycles too long or 2^LOW_BITS cycles too short. This happens in the first second of a minute, and a bad sample of `cal_i` only appears one minute later. The bench therefore times every interval between seconds ticks against a model that works out the trimmed minutes from the minute count it keeps itself. A corrupted minute index shows up as a misplaced trim or a misplaced minute tick, at the latest within one full 64-minute cycle, including across the wrap. A test prescaler that is wrongly coupled to the trim shows up in `ft_o` toggle spacing within the first blanked second.

// File: rtl/tkdiv_pkg.sv
package tkdiv_pkg;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_SLOW = 2'd1,
    TRIM_FAST = 2'd2
  } trim_e;

  // A minute is trimmed when its index lies below twice the magnitude
  // and inside the eligible part of the cycle.
  function automatic logic minute_is_trimmed(input int unsigned idx,
                                             input int unsigned mag,
                                             input int unsigned eligible);
    return (mag != 0) && (idx < 2 * mag) && (idx < eligible);
  endfunction

  function automatic trim_e pick_trim(input logic hit, input logic faster);
    if (!hit) return TRIM_NONE;
    return faster ? TRIM_FAST : TRIM_SLOW;
  endfunction

endpackage

// File: rtl/tkd_prescale.sv
module tkd_prescale #(
  parameter int LOW_BITS  = 8,
  parameter int HIGH_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow_req,
  input  logic fast_req,
  output logic sec_wrap,
  output logic blank_done
);
  localparam int DIV_W  = LOW_BITS + HIGH_BITS;
  localparam int HOLD_W = LOW_BITS - 1;
  localparam int BLANK  = 2 ** (LOW_BITS - 1);
  localparam int ADV    = 2 ** LOW_BITS;

  logic [DIV_W-1:0]  phase;
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_last;

  assign hold_last  = (hold_cnt == HOLD_W'(BLANK - 1));
  assign blank_done = run && slow_req && hold_last;
  assign sec_wrap   = run && !slow_req && (phase == {DIV_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      hold_cnt <= '0;
    end else if (run) begin
      if (slow_req) begin
        hold_cnt <= hold_last ? '0 : hold_cnt + 1'b1;
      end else if (fast_req) begin
        phase <= phase + DIV_W'(ADV + 1);
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  p_trim_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    (slow_req || fast_req) |-> (phase == '0));
  p_hold_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (run && slow_req) |=> $stable(phase));
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(phase) && $stable(hold_cnt)));
  p_single_trim_r3: assert property (@(posedge clk) disable iff (rst)
    !(slow_req && fast_req));

endmodule

// File: rtl/tkd_minute_sched.sv
module tkd_minute_sched
  import tkdiv_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_BITS    = 6,
  parameter int MAG_BITS    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sec_wrap,
  input  logic              blank_done,
  input  logic [MAG_BITS:0] cal_i,
  output logic              trim_slow,
  output logic              trim_fast,
  output logic              min_wrap
);
  localparam int SEC_W     = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_CYCLE = 2 ** MIN_BITS;
  localparam int ELIGIBLE  = MIN_CYCLE - 2;

  logic [SEC_W-1:0]    sec_idx;
  logic [MIN_BITS-1:0] min_idx;
  logic [MIN_BITS-1:0] next_min;
  logic                last_sec;
  logic                next_hit;
  trim_e               mode;

  assign last_sec  = (sec_idx == SEC_W'(SEC_PER_MIN - 1));
  assign next_min  = min_idx + 1'b1;
  assign min_wrap  = sec_wrap && last_sec;
  assign next_hit  = minute_is_trimmed(32'(next_min), 32'(cal_i[MAG_BITS-1:0]),
                                       ELIGIBLE);
  assign trim_slow = (mode == TRIM_SLOW);
  assign trim_fast = (mode == TRIM_FAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx <= '0;
      min_idx <= '0;
      mode    <= TRIM_NONE;
    end else if (run) begin
      if (sec_wrap) begin
        if (last_sec) begin
          sec_idx <= '0;
          min_idx <= next_min;
          mode    <= pick_trim(next_hit, cal_i[MAG_BITS]);
        end else begin
          sec_idx <= sec_idx + 1'b1;
        end
      end else if (mode == TRIM_FAST) begin
        mode <= TRIM_NONE;
      end else if (mode == TRIM_SLOW && blank_done) begin
        mode <= TRIM_NONE;
      end
    end
  end

  p_trim_window_r7: assert property (@(posedge clk) disable iff (rst)
    (mode != TRIM_NONE) |-> (min_idx < MIN_BITS'(ELIGIBLE)));
  p_trim_first_sec_r3: assert property (@(posedge clk) disable iff (rst)
    (mode != TRIM_NONE) |-> (sec_idx == '0));
  p_min_wraps_r7: assert property (@(posedge clk) disable iff (rst)
    (min_wrap && min_idx == {MIN_BITS{1'b1}}) |=> (min_idx == '0));

endmodule

// File: rtl/tkd_freq_test.sv
module tkd_freq_test #(
  parameter int FT_BITS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ftest,
  input  logic afe,
  input  logic wds,
  input  logic wd_zero,
  output logic ft_o
);
  logic [FT_BITS-1:0] ft_cnt;
  logic               gate_open;
  logic               ft_q;

  assign gate_open = run && ftest && !afe && (wds || wd_zero);
  assign ft_o      = ft_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_cnt <= '0;
      ft_q   <= 1'b0;
    end else begin
      if (run) ft_cnt <= ft_cnt + 1'b1;
      ft_q <= gate_open && ft_cnt[FT_BITS-1];
    end
  end

  p_gate_closed_r10: assert property (@(posedge clk) disable iff (rst)
    !gate_open |=> !ft_q);
  p_count_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(ft_cnt));

endmodule

// File: rtl/tkdiv_top.sv
module tkdiv_top #(
  parameter int LOW_BITS    = 8,
  parameter int HIGH_BITS   = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_BITS    = 6,
  parameter int MAG_BITS    = 5,
  parameter int FT_BITS     = 6
) (
  input  logic              clk_osc_i,
  input  logic              rst_i,
  input  logic [MAG_BITS:0] cal_i,
  input  logic              stop_i,
  input  logic              ftest_i,
  input  logic              afe_i,
  input  logic              wds_i,
  input  logic              wd_zero_i,
  output logic              sec_tick_o,
  output logic              min_tick_o,
  output logic              ft_o
);
  logic run;
  logic trim_slow;
  logic trim_fast;
  logic sec_wrap;
  logic blank_done;
  logic min_wrap;
  logic sec_tick_q;
  logic min_tick_q;

  assign run = !stop_i;

  tkd_prescale #(
    .LOW_BITS (LOW_BITS),
    .HIGH_BITS(HIGH_BITS)
  ) u_prescale (
    .clk       (clk_osc_i),
    .rst       (rst_i),
    .run       (run),
    .slow_req  (trim_slow),
    .fast_req  (trim_fast),
    .sec_wrap  (sec_wrap),
    .blank_done(blank_done)
  );

  tkd_minute_sched #(
    .SEC_PER_MIN(SEC_PER_MIN),
    .MIN_BITS   (MIN_BITS),
    .MAG_BITS   (MAG_BITS)
  ) u_sched (
    .clk       (clk_osc_i),
    .rst       (rst_i),
    .run       (run),
    .sec_wrap  (sec_wrap),
    .blank_done(blank_done),
    .cal_i     (cal_i),
    .trim_slow (trim_slow),
    .trim_fast (trim_fast),
    .min_wrap  (min_wrap)
  );

  tkd_freq_test #(
    .FT_BITS(FT_BITS)
  ) u_ftest (
    .clk    (clk_osc_i),
    .rst    (rst_i),
    .run    (run),
    .ftest  (ftest_i),
    .afe    (afe_i),
    .wds    (wds_i),
    .wd_zero(wd_zero_i),
    .ft_o   (ft_o)
  );

  always_ff @(posedge clk_osc_i) begin
    if (rst_i) begin
      sec_tick_q <= 1'b0;
      min_tick_q <= 1'b0;
    end else begin
      sec_tick_q <= sec_wrap;
      min_tick_q <= min_wrap;
    end
  end

  assign sec_tick_o = sec_tick_q;
  assign min_tick_o = min_tick_q;

  p_min_on_sec_r2: assert property (@(posedge clk_osc_i) disable iff (rst_i)
    min_tick_o |-> sec_tick_o);
  p_stop_silent_r8: assert property (@(posedge clk_osc_i) disable iff (rst_i)
    !run |=> !sec_tick_o);

endmodule

// File: tb/tb_tkdiv_top.sv
module tb_tkdiv_top;
  localparam int LOW_BITS  = 4;
  localparam int HIGH_BITS = 3;
  localparam int SPM       = 4;
  localparam int MIN_BITS  = 6;
  localparam int FT_BITS   = 3;
  localparam int SEC_LEN   = 2 ** (LOW_BITS + HIGH_BITS);
  localparam int SLOW_BY   = 2 ** (LOW_BITS - 1);
  localparam int FAST_BY   = 2 ** LOW_BITS;
  localparam int CYC_MIN   = 2 ** MIN_BITS;
  localparam int FT_HALF   = 2 ** (FT_BITS - 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cal = 6'h00;
  logic       stop = 1'b0, ftest = 1'b0, afe = 1'b0, wds = 1'b1, wdz = 1'b0;
  logic       sec_tick, min_tick, ft;

  always #10 clk = ~clk;

  tkdiv_top #(
    .LOW_BITS(LOW_BITS), .HIGH_BITS(HIGH_BITS), .SEC_PER_MIN(SPM),
    .MIN_BITS(MIN_BITS), .MAG_BITS(5), .FT_BITS(FT_BITS)
  ) dut (
    .clk_osc_i(clk), .rst_i(rst), .cal_i(cal), .stop_i(stop),
    .ftest_i(ftest), .afe_i(afe), .wds_i(wds), .wd_zero_i(wdz),
    .sec_tick_o(sec_tick), .min_tick_o(min_tick), .ft_o(ft)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    exp_q[$];
  string tag_q[$];
  int    edge_cnt = 0;
  int    last_edge = 0;
  int    ticks = 0;
  bit    mon_on = 0;
  bit    ft_watch = 0;
  int    ft_toggles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] sched(input int m);
    if (m <= 3) return 6'h01;
    if (m <= 9) return 6'h23;
    if (m <= 15) return 6'h06;
    if (m <= 20) return 6'h20;
    return 6'h3F;
  endfunction

  // Independent statement of the trim rule: minute pairs below the magnitude.
  function automatic int second_len(input int idx, input logic [5:0] c, input int s);
    int mag = int'(c[4:0]);
    if (s != 0 || mag == 0) return SEC_LEN;
    if (idx >= CYC_MIN - 2) return SEC_LEN;
    if ((idx / 2) >= mag) return SEC_LEN;
    return c[5] ? SEC_LEN - FAST_BY : SEC_LEN + SLOW_BY;
  endfunction

  function automatic string second_tag(input int idx, input logic [5:0] c, input int s);
    if (s != 0) return "R2";
    if (c[4:0] == 0) return "R3";
    if (idx >= CYC_MIN - 2) return "R7";
    if ((idx / 2) >= int'(c[4:0])) return "R3";
    return c[5] ? "R5" : "R4";
  endfunction

  task automatic push_minute(input int idx, input logic [5:0] c, input bit first);
    for (int s = 0; s < SPM; s++) begin
      exp_q.push_back(second_len(idx, c, s));
      tag_q.push_back(first ? "R6" : second_tag(idx, c, s));
    end
  endtask

  always @(posedge clk) if (!rst && !stop) edge_cnt++;

  // Monitor: time each second and compare against the scoreboard.
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      if (sec_tick) begin
        int iv;
        iv = edge_cnt - last_edge;
        last_edge = edge_cnt;
        ticks++;
        if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(iv == e, t, iv, e);
        end
        check(min_tick == ((ticks % SPM) == 0), "R2", int'(min_tick), int'((ticks % SPM) == 0));
      end else if (min_tick) begin
        check(1'b0, "R2", 1, 0);
      end
    end
  end

  // Test output spacing monitor (R9).
  int  ft_gap = 0;
  bit  ft_have = 0;
  logic ft_prev = 1'b0;
  always @(negedge clk) begin
    if (ft_watch) begin
      ft_gap++;
      if (ft !== ft_prev) begin
        if (ft_have) check(ft_gap == FT_HALF, "R9", ft_gap, FT_HALF);
        ft_have = 1;
        ft_gap = 0;
        ft_toggles++;
      end
      ft_prev = ft;
    end else begin
      ft_have = 0;
      ft_gap = 0;
      ft_prev = ft;
    end
  end

  task automatic wait_min_tick();
    do @(negedge clk); while (!min_tick);
  endtask

  task automatic wait_sec_tick();
    do @(negedge clk); while (!sec_tick);
  endtask

  task automatic observe_ft(input int cycles, output int tog, output int highs);
    logic p;
    tog = 0;
    highs = 0;
    @(negedge clk);
    p = ft;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ft !== p) tog++;
      if (ft === 1'b1) highs++;
      p = ft;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int tog, highs, stopped_ticks;
    // R1: quiet outputs in reset, test enable requested
    rst = 1'b1; ftest = 1'b1; cal = 6'h3F;
    repeat (5) @(negedge clk);
    check(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
    check(min_tick == 1'b0, "R1", int'(min_tick), 0);
    check(ft == 1'b0, "R1", int'(ft), 0);
    ftest = 1'b0;
    cal = sched(1);
    rst = 1'b0;
    mon_on = 1;
    // R6: minute 0 after reset is untrimmed although cal is set
    push_minute(0, 6'h00, 1'b1);
    push_minute(1, sched(1), 1'b0);

    for (int m = 1; m < 70; m++) begin
      wait_min_tick();
      cal = 6'h00;            // R6: disturbance during the trimmed second
      wait_sec_tick();
      if (m == 3) begin
        stop = 1'b1;          // R8
        stopped_ticks = 0;
        repeat (200) begin
          @(negedge clk);
          if (sec_tick) stopped_ticks++;
        end
        check(stopped_ticks == 0, "R8", stopped_ticks, 0);
        stop = 1'b0;
      end
      cal = sched(m + 1);
      push_minute((m + 1) % CYC_MIN, sched(m + 1), 1'b0);
    end
    while (exp_q.size() != 0) @(negedge clk);

    // R9: test output during a slowing minute
    push_minute(71 % CYC_MIN, sched(70), 1'b0);
    cal = 6'h1F;
    push_minute(72 % CYC_MIN, 6'h1F, 1'b0);
    ftest = 1'b1; afe = 1'b0; wds = 1'b1; wdz = 1'b0;
    repeat (10) @(negedge clk);
    ft_watch = 1;
    while (exp_q.size() != 0) @(negedge clk);
    ft_watch = 0;
    check(ft_toggles > 100, "R9", ft_toggles, 101);

    // R10: gating conditions
    afe = 1'b1;
    repeat (4) @(negedge clk);
    observe_ft(40, tog, highs);
    check(highs == 0, "R10", highs, 0);
    afe = 1'b0; wds = 1'b0; wdz = 1'b0;
    repeat (4) @(negedge clk);
    observe_ft(40, tog, highs);
    check(highs == 0, "R10", highs, 0);
    wdz = 1'b1;
    repeat (4) @(negedge clk);
    observe_ft(40, tog, highs);
    check(tog >= 8, "R10", tog, 8);
    wdz = 1'b0; wds = 1'b1; ftest = 1'b0;
    repeat (4) @(negedge clk);
    observe_ft(40, tog, highs);
    check(highs == 0, "R10", highs, 0);
    ftest = 1'b1; stop = 1'b1;
    repeat (4) @(negedge clk);
    observe_ft(40, tog, highs);
    check(highs == 0, "R8", highs, 0);
    stop = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule